// File: doc/BRIEF.md
# Load Ordering Buffer

This block keeps a small circular record of the loads an out-of-order core has in flight, held in program order. A load claims a slot when it is dispatched and receives the slot number as its tag. When the load issues, its memory address is written into that slot. From then on the slot can take part in ordering checks. When a store executes, it presents its address together with the buffer's tail position, which was sampled when the store was dispatched. The block then finds the loads that were dispatched after that store, have already issued and used the same address. It reports the oldest of them as a memory-ordering violation, so that the pipeline can flush from that load.

Slots are released in two ways. A commit frees the oldest slot. A flush from a given tag frees that slot and every younger one, and the tail is moved back to that tag. Each slot is a three-state machine:
- `SLOT_FREE`: the slot is unused.
- `SLOT_WAIT`: the slot is allocated and its address is not yet known.
- `SLOT_READY`: the address is recorded.

The slot transitions are:
- alloc: `SLOT_FREE` to `SLOT_WAIT`
- issue: `SLOT_WAIT` to `SLOT_READY`
- release, caused by a commit or a flush: `SLOT_WAIT` or `SLOT_READY` to `SLOT_FREE`

A head pointer and a tail pointer, each with one wrap bit above the slot index, give the age of every slot. Loading data and forwarding store data are handled elsewhere.

Top module: `load_order_buffer`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `alloc_tag`=0, `tail_pos`=0 and `viol_valid`=0.
- R2: An accepted allocation gives the load the tag shown on `alloc_tag`. Tags advance by one per accepted allocation and wrap modulo DEPTH. `tail_pos` is the allocation count modulo 2*DEPTH: the slot index with one wrap bit above it.
- R3: `full` is 1 when DEPTH slots are allocated. An allocation request made while `full` is 1 is ignored: the tag and the occupancy are unchanged.
- R4: An address written by an issue becomes visible to store checks from the cycle after the issue. A store check in the same cycle as the issue does not see it.
- R5: A store check with position P flags only `SLOT_READY` loads with an equal address whose tail position is P or later. Position P is the `tail_pos` sampled at the store's dispatch. Older loads are ignored, and this also holds across pointer wrap.
- R6: When several loads qualify, `viol_tag` names the oldest in program order, not the lowest index. `viol_valid`/`viol_tag` are registered and appear in the cycle after the check.
- R7: A commit frees the head slot. The following cycle `full` is 0 and that slot can be allocated again.
- R8: A flush from tag T frees T and every younger slot, and the next allocation returns tag T.
- R9: A load that is allocated but has not issued (`SLOT_WAIT`) never matches a store check.
- R10: In a cycle with a flush, allocation and commit requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Dispatch a load: claim the slot shown on alloc_tag |
| alloc_tag | output | IDX_W | Tag the next accepted allocation receives |
| tail_pos | output | PTR_W | Tail position with wrap bit, sampled by stores at dispatch |
| full | output | 1 | All slots allocated |
| empty | output | 1 | No slot allocated |
| issue_valid | input | 1 | A load has issued |
| issue_tag | input | IDX_W | Tag of the issuing load |
| issue_addr | input | ADDR_W | Address of the issuing load |
| st_chk_valid | input | 1 | An executing store requests an ordering check |
| st_chk_pos | input | PTR_W | The store's tail position from its dispatch |
| st_chk_addr | input | ADDR_W | The store's address |
| commit_valid | input | 1 | Retire the oldest load |
| flush_valid | input | 1 | Flush from flush_tag onward |
| flush_tag | input | IDX_W | Oldest tag to flush |
| viol_valid | output | 1 | Ordering violation found by the previous cycle's check |
| viol_tag | output | IDX_W | Tag of the oldest violating load |

## Verification
`alloc_tag`, `tail_pos`, `full` and `empty` change at the rising edge that accepts an allocation, commit or flush. They are therefore due one cycle after the request is driven. An issued address can only be seen by a check made one cycle after the issue. A check's verdict on `viol_valid`/`viol_tag` is due exactly one cycle after the check. The bench drives every input on the falling edge and reads the results on the next falling edge. A monitor pops one expected verdict for every check accepted at the rising edge in between, so each result is compared in the cycle it is due.

// File: rtl/lob_pkg.sv
package lob_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/lob_slot.sv
module lob_slot
    import lob_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              issue_i,
    input  logic [ADDR_W-1:0] issue_addr_i,
    input  logic              free_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              hit_o
);
    slot_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // next state: release wins over everything else
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (alloc_i) state_d = SLOT_WAIT;
            SLOT_WAIT:  if (free_i) state_d = SLOT_FREE;
                        else if (issue_i) state_d = SLOT_READY;
            SLOT_READY: if (free_i) state_d = SLOT_FREE;
            default:    state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else if (state_q == SLOT_WAIT && issue_i && !free_i) addr_q <= issue_addr_i;
    end

    // outputs
    always_comb hit_o = (state_q == SLOT_READY) && (addr_q == probe_addr_i);

    AST_NO_ISSUE_WHILE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_FREE && !alloc_i) |=> !hit_o); // R9
endmodule

// File: rtl/lob_pick.sv
module lob_pick #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    parameter int PTR_W = 3
) (
    input  logic [DEPTH-1:0] hit_i,
    input  logic [IDX_W-1:0] head_idx_i,
    input  logic [PTR_W-1:0] start_dist_i,
    output logic             found_o,
    output logic [IDX_W-1:0] tag_o
);
    logic [IDX_W-1:0] idx;

    // walk from youngest to oldest so the oldest qualifying slot is kept last
    always_comb begin
        found_o = 1'b0;
        tag_o   = '0;
        idx     = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = head_idx_i + IDX_W'(k);
            if (hit_i[idx] && (PTR_W'(k) >= start_dist_i)) begin
                found_o = 1'b1;
                tag_o   = idx;
            end
        end
    end
endmodule

// File: rtl/lob_ptrs.sv
module lob_ptrs #(
    parameter int IDX_W = 2,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire_i,
    input  logic             commit_fire_i,
    input  logic             flush_fire_i,
    input  logic [IDX_W-1:0] flush_dist_i,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_o <= '0;
            tail_o <= '0;
        end else begin
            if (commit_fire_i) head_o <= head_o + PTR_W'(1);
            if (flush_fire_i)      tail_o <= head_o + PTR_W'(flush_dist_i);
            else if (alloc_fire_i) tail_o <= tail_o + PTR_W'(1);
        end
    end
endmodule

// File: rtl/load_order_buffer.sv
module load_order_buffer #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic [IDX_W-1:0]  alloc_tag,
    output logic [PTR_W-1:0]  tail_pos,
    output logic              full,
    output logic              empty,
    input  logic              issue_valid,
    input  logic [IDX_W-1:0]  issue_tag,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              st_chk_valid,
    input  logic [PTR_W-1:0]  st_chk_pos,
    input  logic [ADDR_W-1:0] st_chk_addr,
    input  logic              commit_valid,
    input  logic              flush_valid,
    input  logic [IDX_W-1:0]  flush_tag,
    output logic              viol_valid,
    output logic [IDX_W-1:0]  viol_tag
);
    logic [PTR_W-1:0] head, tail, count, start_dist;
    logic [IDX_W-1:0] head_idx, flush_dist;
    logic [IDX_W-1:0] slot_dist [DEPTH];
    logic [DEPTH-1:0] slot_hit, slot_free, in_flight;
    logic alloc_fire, commit_fire, pick_found;
    logic [IDX_W-1:0] pick_tag;

    assign head_idx    = head[IDX_W-1:0];
    assign count       = tail - head;
    assign full        = (count == PTR_W'(DEPTH));
    assign empty       = (count == '0);
    assign alloc_tag   = tail[IDX_W-1:0];
    assign tail_pos    = tail;
    assign alloc_fire  = alloc_req && !full && !flush_valid;
    assign commit_fire = commit_valid && !empty && !flush_valid;
    assign flush_dist  = flush_tag - head_idx;
    assign start_dist  = st_chk_pos - head;

    lob_ptrs #(.IDX_W(IDX_W), .PTR_W(PTR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire_i(alloc_fire), .commit_fire_i(commit_fire),
        .flush_fire_i(flush_valid), .flush_dist_i(flush_dist),
        .head_o(head), .tail_o(tail)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_dist[g] = IDX_W'(g) - head_idx;
        assign in_flight[g] = ({1'b0, slot_dist[g]} < count);
        assign slot_free[g] = (commit_fire && head_idx == IDX_W'(g)) ||
                              (flush_valid && in_flight[g] && slot_dist[g] >= flush_dist);
        lob_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_fire && alloc_tag == IDX_W'(g)),
            .issue_i(issue_valid && issue_tag == IDX_W'(g)),
            .issue_addr_i(issue_addr),
            .free_i(slot_free[g]),
            .probe_addr_i(st_chk_addr),
            .hit_o(slot_hit[g])
        );
    end

    lob_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_pick (
        .hit_i(slot_hit), .head_idx_i(head_idx), .start_dist_i(start_dist),
        .found_o(pick_found), .tag_o(pick_tag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_tag   <= '0;
        end else begin
            viol_valid <= st_chk_valid && pick_found;
            viol_tag   <= pick_tag;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(DEPTH)); // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_req && !commit_valid && !flush_valid) |=> (full && alloc_tag == $past(alloc_tag))); // R3
    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !full && !flush_valid) |=> (alloc_tag == $past(alloc_tag) + IDX_W'(1))); // R2
    AST_COMMIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && commit_valid && !flush_valid) |=> !full); // R7
    AST_FLUSH_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (alloc_tag == $past(flush_tag))); // R8
    AST_VIOL_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(st_chk_valid)); // R6
    AST_PICK_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> slot_hit[pick_tag]); // R5
endmodule

// File: tb/load_order_buffer_test.sv
module load_order_buffer_test;
    localparam int DEPTH = 4, ADDR_W = 32, IDX_W = 2, PTR_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_req = 0, issue_valid = 0, st_chk_valid = 0, commit_valid = 0, flush_valid = 0;
    logic [IDX_W-1:0] issue_tag = '0, flush_tag = '0;
    logic [ADDR_W-1:0] issue_addr = '0, st_chk_addr = '0;
    logic [PTR_W-1:0] st_chk_pos = '0;
    logic [IDX_W-1:0] alloc_tag, viol_tag;
    logic [PTR_W-1:0] tail_pos;
    logic full, empty, viol_valid;

    int checks = 0, errors = 0;
    bit done = 0, chk_seen = 0;
    bit exp_v[$];
    int exp_t[$];
    string exp_r[$];

    always #4 clk = ~clk; // 125 MHz

    load_order_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_tag(alloc_tag),
        .tail_pos(tail_pos), .full(full), .empty(empty), .issue_valid(issue_valid),
        .issue_tag(issue_tag), .issue_addr(issue_addr), .st_chk_valid(st_chk_valid),
        .st_chk_pos(st_chk_pos), .st_chk_addr(st_chk_addr), .commit_valid(commit_valid),
        .flush_valid(flush_valid), .flush_tag(flush_tag), .viol_valid(viol_valid),
        .viol_tag(viol_tag)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic alloc1();
        alloc_req = 1; step(); alloc_req = 0;
    endtask

    task automatic issue1(int tag, logic [ADDR_W-1:0] a);
        issue_valid = 1; issue_tag = IDX_W'(tag); issue_addr = a; step(); issue_valid = 0;
    endtask

    // driver: push the expected verdict, then present the check for one cycle
    task automatic store_chk(int pos, logic [ADDR_W-1:0] a, bit ev, int et, string req);
        exp_v.push_back(ev); exp_t.push_back(et); exp_r.push_back(req);
        st_chk_valid = 1; st_chk_pos = PTR_W'(pos); st_chk_addr = a;
        step();
        st_chk_valid = 0;
    endtask

    // monitor: a check accepted at the last rising edge has its verdict now
    always @(posedge clk) chk_seen <= st_chk_valid;
    always @(negedge clk) begin
        if (chk_seen) begin
            if (exp_v.size() == 0) chk("scoreboard", "unexpected verdict", 1, 0);
            else begin
                bit ev; int et; string r;
                ev = exp_v.pop_front(); et = exp_t.pop_front(); r = exp_r.pop_front();
                chk(r, "viol_valid", int'(viol_valid), int'(ev));
                if (ev) chk(r, "viol_tag", int'(viol_tag), et);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "alloc_tag", int'(alloc_tag), 0);
        chk("R1", "tail_pos", int'(tail_pos), 0);
        chk("R1", "viol_valid", int'(viol_valid), 0);

        // R2 sequential tags; a store is taken to dispatch after the second load
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2", "alloc_tag", int'(alloc_tag), i);
            if (i == 2) chk("R2", "tail_pos", int'(tail_pos), 2);
            alloc1();
        end
        chk("R3", "full after DEPTH allocs", int'(full), 1);

        issue1(0, 32'hA0);
        issue1(1, 32'hB0);
        // R9 / R5: slot 0 older, slots 2 and 3 not issued
        store_chk(2, 32'hA0, 0, 0, "R9");
        // R4: issue and check in the same cycle -> not seen
        exp_v.push_back(0); exp_t.push_back(0); exp_r.push_back("R4");
        issue_valid = 1; issue_tag = 2; issue_addr = 32'hA0;
        st_chk_valid = 1; st_chk_pos = 2; st_chk_addr = 32'hA0;
        step();
        issue_valid = 0; st_chk_valid = 0;
        store_chk(2, 32'hA0, 1, 2, "R4");
        issue1(3, 32'hA0);
        store_chk(2, 32'hA0, 1, 2, "R6");   // slots 2 and 3 match, oldest is 2
        store_chk(3, 32'hA0, 1, 3, "R5");   // slot 2 now older than the store
        store_chk(0, 32'hA0, 1, 0, "R6");
        store_chk(2, 32'hB0, 0, 0, "R5");   // slot 1 matches but is older

        // R3 alloc while full ignored
        alloc1();
        chk("R3", "full held", int'(full), 1);
        chk("R3", "alloc_tag held", int'(alloc_tag), 0);

        // R7 commit frees head, slot reusable next cycle
        commit_valid = 1; step(); commit_valid = 0;
        chk("R7", "full after commit", int'(full), 0);
        chk("R7", "alloc_tag", int'(alloc_tag), 0);
        alloc1();
        chk("R7", "full after realloc", int'(full), 1);

        // R8 / R10 flush from tag 2 with alloc and commit also asserted
        flush_valid = 1; flush_tag = 2; alloc_req = 1; commit_valid = 1;
        step();
        flush_valid = 0; alloc_req = 0; commit_valid = 0;
        chk("R8", "alloc_tag after flush", int'(alloc_tag), 2);
        chk("R8", "full after flush", int'(full), 0);
        chk("R10", "commit ignored (not empty)", int'(empty), 0);
        store_chk(1, 32'hA0, 0, 0, "R8");   // flushed slots 2,3 no longer match
        commit_valid = 1; step(); commit_valid = 0;
        chk("R10", "empty after single commit", int'(empty), 1);

        // wrap: loads at positions 2,3,4,5 get tags 2,3,0,1
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2", "wrapped alloc_tag", int'(alloc_tag), (i + 2) % DEPTH);
            alloc1();
        end
        issue1(0, 32'hD0);
        issue1(2, 32'hD0);
        store_chk(3, 32'hD0, 1, 0, "R5");   // only the wrapped load is younger
        store_chk(2, 32'hD0, 1, 2, "R6");   // oldest by age, not lowest index
        step();
        step();
        chk("scoreboard", "pending verdicts", exp_v.size(), 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule